// File: doc/BRIEF.md
# Period Timer PWM Generator

This block holds one shared 8-bit period timer and a set of PWM channels that run from it. A clock divider feeds the timer. It advances the timer once every 4, 16 or 64 clocks, and the prescale select picks which. The timer counts up to a programmed period value. On the step after it reaches that value, the timer returns to zero. That step is the period boundary. A postscaler counts these boundaries and raises a sticky interrupt flag once every N of them.

Each channel holds a 10-bit duty value. Software writes it in two independent parts: an 8-bit high part and a 2-bit low part. The written value sits in a master register. It moves into the active (slave) register only at a period boundary, so a write in the middle of a period cannot disturb the waveform. The active register is visible on a readback port.

The output of a channel is high while a 10-bit fine position is below the active duty. The fine position is the timer count with two extra low bits that tell which quarter of the current timer step the divider is in. Every channel shares the same timer, so all channels have the same period and all rise together.

Top module: `pwm_timer_top`

## Requirements
- R1: With `tmr_en` high, the timer steps once every 4×PS clocks and counts 0,1,…,`period`, then returns to 0 on the following step (the period boundary). A period therefore lasts (`period`+1)×4×PS clocks. With `tmr_en` low, the timer and divider hold, and neither `pwm_out` nor `duty_active` changes.
- R2: `pre_sel` encoding: 0 gives PS=1, 1 gives PS=4, 2 or 3 gives PS=16.
- R3: The postscaler sets `tmr_flag` on every (`post_sel`+1)-th period boundary. The flag stays set until `flag_clr` is sampled high. If a set and a clear fall in the same cycle, the set wins.
- R4: A high on `duty_hi_we[c]` loads channel c's master bits [9:2] from its `duty_hi` byte. A high on `duty_lo_we[c]` loads master bits [1:0] from its `duty_lo` pair. `duty_active` (channel c at bits [10c+9:10c]) shows the slave value. The slave copies the master, as it stood before the edge, only on a period boundary.
- R5: After each clock edge, `pwm_out[c]` is high exactly when F < D. Here F = 4×timer + (clocks into the current step ÷ PS), and D is the slave duty. The output therefore rises at a boundary and stays high for D×PS clocks.
- R6: A slave duty of 0 keeps the output low for the whole period. A slave duty of 4×(`period`+1) or more keeps it high for the whole period.
- R7: All channels share one timer, so they see the same boundaries and rise on the same edge, while each channel's high time follows its own duty.
- R8: Synchronous active-high `rst` clears the timer, divider, postscaler, flag and all duty registers. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Timer run enable |
| pre_sel | input | 2 | Prescale select (1, 4, 16) |
| post_sel | input | 4 | Boundaries per flag, minus one |
| period | input | 8 | Last timer count of a period |
| flag_clr | input | 1 | Clears the interrupt flag |
| duty_hi_we | input | NCH | Per-channel write strobe, high duty part |
| duty_hi | input | NCH×8 | High duty parts, channel c at [8c+7:8c] |
| duty_lo_we | input | NCH | Per-channel write strobe, low duty part |
| duty_lo | input | NCH×2 | Low duty parts, channel c at [2c+1:2c] |
| pwm_out | output | NCH | Registered PWM outputs |
| tmr_flag | output | 1 | Sticky postscaled period flag |
| duty_active | output | NCH×10 | Slave duty readback |

## Verification
The assertions assume that `period`, `pre_sel` and `post_sel` do not change while the timer runs. A change in mid-count could push the timer past the period value and wrap it at 255 with no boundary. The bench changes these settings only while reset is held, and it starts every scenario from reset. Duty writes, flag clears and enable drops arrive at any point in a period. This exercises the master/slave split and the hold behaviour under the same assumptions.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int FRAC_W = 2;
  localparam int DIV_W  = 6;

  // last divider value of one timer step: 4*PS - 1
  function automatic logic [DIV_W-1:0] step_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    step_limit = 6'd3;
      2'd1:    step_limit = 6'd15;
      default: step_limit = 6'd63;
    endcase
  endfunction

  // quarter of the current step: divider value divided by PS
  function automatic logic [FRAC_W-1:0] step_phase(input logic [DIV_W-1:0] d,
                                                   input logic [1:0] sel);
    case (sel)
      2'd0:    step_phase = d[1:0];
      2'd1:    step_phase = d[3:2];
      default: step_phase = d[5:4];
    endcase
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase import pwm_pkg::*; #(
  parameter int CNT_W = 8,
  localparam int FINE_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        pre_sel,
  input  logic [CNT_W-1:0]  period,
  output logic              period_end,
  output logic [FINE_W-1:0] fine_next
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step_done, at_top;

  always_comb begin
    step_done  = div_q >= step_limit(pre_sel);
    at_top     = cnt_q == period;
    period_end = en && step_done && at_top;
    div_d      = div_q;
    cnt_d      = cnt_q;
    if (en) begin
      if (step_done) begin
        div_d = '0;
        cnt_d = at_top ? '0 : cnt_q + CNT_W'(1);
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
    fine_next = {cnt_d, step_phase(div_d, pre_sel)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwm_postscaler.sv
module pwm_postscaler #(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              period_end,
  input  logic [POST_W-1:0] post_sel,
  input  logic              flag_clr,
  output logic              flag
);
  logic [POST_W-1:0] seen_q;
  logic              hit;

  assign hit = period_end && (seen_q >= post_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      flag   <= 1'b0;
    end else begin
      if (period_end) seen_q <= hit ? '0 : seen_q + POST_W'(1);
      if (hit)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_duty_unit.sv
module pwm_duty_unit import pwm_pkg::*; #(
  parameter int HI_W = 8,
  localparam int DUTY_W = HI_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              period_end,
  input  logic [DUTY_W-1:0] fine_next,
  input  logic              hi_we,
  input  logic [HI_W-1:0]   hi_din,
  input  logic              lo_we,
  input  logic [FRAC_W-1:0] lo_din,
  output logic [DUTY_W-1:0] duty_q,
  output logic              pwm
);
  logic [HI_W-1:0]   mst_hi;
  logic [FRAC_W-1:0] mst_lo;
  logic [DUTY_W-1:0] duty_d;

  assign duty_d = period_end ? {mst_hi, mst_lo} : duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_hi <= '0;
      mst_lo <= '0;
      duty_q <= '0;
      pwm    <= 1'b0;
    end else begin
      if (hi_we) mst_hi <= hi_din;
      if (lo_we) mst_lo <= lo_din;
      duty_q <= duty_d;
      pwm    <= fine_next < duty_d;
    end
  end
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top import pwm_pkg::*; #(
  parameter int CNT_W  = 8,
  parameter int NCH    = 2,
  parameter int POST_W = 4,
  localparam int DUTY_W = CNT_W + FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tmr_en,
  input  logic [1:0]            pre_sel,
  input  logic [POST_W-1:0]     post_sel,
  input  logic [CNT_W-1:0]      period,
  input  logic                  flag_clr,
  input  logic [NCH-1:0]        duty_hi_we,
  input  logic [NCH*CNT_W-1:0]  duty_hi,
  input  logic [NCH-1:0]        duty_lo_we,
  input  logic [NCH*FRAC_W-1:0] duty_lo,
  output logic [NCH-1:0]        pwm_out,
  output logic                  tmr_flag,
  output logic [NCH*DUTY_W-1:0] duty_active
);
  logic              period_end;
  logic [DUTY_W-1:0] fine_next;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .en(tmr_en), .pre_sel(pre_sel), .period(period),
    .period_end(period_end), .fine_next(fine_next)
  );

  pwm_postscaler #(.POST_W(POST_W)) u_post (
    .clk(clk), .rst(rst), .period_end(period_end), .post_sel(post_sel),
    .flag_clr(flag_clr), .flag(tmr_flag)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_duty_unit #(.HI_W(CNT_W)) u_duty (
      .clk(clk), .rst(rst), .period_end(period_end), .fine_next(fine_next),
      .hi_we(duty_hi_we[c]), .hi_din(duty_hi[c*CNT_W +: CNT_W]),
      .lo_we(duty_lo_we[c]), .lo_din(duty_lo[c*FRAC_W +: FRAC_W]),
      .duty_q(duty_active[c*DUTY_W +: DUTY_W]), .pwm(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int NCH    = 2,
  parameter int DUTY_W = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tmr_en,
  input logic                  period_end,
  input logic [NCH-1:0]        pwm_out,
  input logic                  tmr_flag,
  input logic [NCH*DUTY_W-1:0] duty_active
);
  // R4: active duty changes only at a boundary
  a_r4_slave_hold: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> $stable(duty_active));

  // R3: flag only rises on a boundary
  a_r3_flag_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(tmr_flag) |-> $past(period_end));

  // R1: disabled timer freezes the outputs
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !tmr_en |=> ($stable(pwm_out) && $stable(duty_active)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R5, R7: every channel rises only at the shared boundary
    a_r5_rise_at_end: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out[c]) |-> $past(period_end));
    // R6: zero duty keeps the output low
    a_r6_zero_low: assert property (@(posedge clk) disable iff (rst)
      (duty_active[c*DUTY_W +: DUTY_W] == '0) |-> !pwm_out[c]);
  end
endmodule

bind pwm_timer_top pwm_timer_chk #(.NCH(NCH), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst(rst), .tmr_en(tmr_en), .period_end(period_end),
  .pwm_out(pwm_out), .tmr_flag(tmr_flag), .duty_active(duty_active)
);

// File: tb/test_pwm_timer_top.sv
module test_pwm_timer_top;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tmr_en = 1'b0;
  logic [1:0]  pre_sel = 2'd0;
  logic [3:0]  post_sel = 4'd0;
  logic [7:0]  period = 8'd0;
  logic        flag_clr = 1'b0;
  logic [1:0]  duty_hi_we = '0;
  logic [15:0] duty_hi = '0;
  logic [1:0]  duty_lo_we = '0;
  logic [3:0]  duty_lo = '0;
  logic [1:0]  pwm_out;
  logic        tmr_flag;
  logic [19:0] duty_active;

  pwm_timer_top i_pwm_timer_top (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .pre_sel(pre_sel), .post_sel(post_sel),
    .period(period), .flag_clr(flag_clr), .duty_hi_we(duty_hi_we), .duty_hi(duty_hi),
    .duty_lo_we(duty_lo_we), .duty_lo(duty_lo), .pwm_out(pwm_out),
    .tmr_flag(tmr_flag), .duty_active(duty_active)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference state
  int m_div = 0, m_tmr = 0, m_post = 0;
  bit m_flag = 0;
  int m_master[NCH];
  int m_slave[NCH];
  bit m_pwm[NCH];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int psv();
    return (pre_sel == 2'd0) ? 1 : (pre_sel == 2'd1) ? 4 : 16;
  endfunction

  task automatic model_step();
    int ps, fine;
    bit bnd;
    if (rst) begin
      m_div = 0; m_tmr = 0; m_post = 0; m_flag = 0;
      for (int c = 0; c < NCH; c++) begin m_master[c] = 0; m_slave[c] = 0; m_pwm[c] = 0; end
      return;
    end
    ps  = psv();
    bnd = tmr_en && (m_div == 4*ps-1) && (m_tmr == int'(period));
    for (int c = 0; c < NCH; c++) begin
      if (bnd) m_slave[c] = m_master[c];
      if (duty_hi_we[c]) m_master[c] = (int'(duty_hi[c*8 +: 8]) * 4) + (m_master[c] % 4);
      if (duty_lo_we[c]) m_master[c] = (m_master[c] / 4) * 4 + int'(duty_lo[c*2 +: 2]);
    end
    if (bnd && m_post == int'(post_sel)) begin m_flag = 1; m_post = 0; end
    else begin
      if (bnd) m_post++;
      if (flag_clr) m_flag = 0;
    end
    if (tmr_en) begin
      if (m_div == 4*ps-1) begin
        m_div = 0;
        m_tmr = (m_tmr == int'(period)) ? 0 : m_tmr + 1;
      end else m_div++;
    end
    fine = m_tmr * 4 + m_div / ps;
    for (int c = 0; c < NCH; c++) m_pwm[c] = fine < m_slave[c];
  endtask

  // one clock: model follows the edge, outputs compared 1 ns later
  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    for (int c = 0; c < NCH; c++) begin
      chk(pwm_out[c] == m_pwm[c], $sformatf("R5 pwm ch%0d", c), pwm_out[c], m_pwm[c]);
      chk(int'(duty_active[c*10 +: 10]) == m_slave[c], $sformatf("R4 readback ch%0d", c),
          duty_active[c*10 +: 10], m_slave[c]);
    end
    chk(tmr_flag == m_flag, "R3 flag", tmr_flag, m_flag);
  endtask

  task automatic start(input logic [1:0] ps, input logic [7:0] per, input logic [3:0] post);
    rst = 1'b1; tmr_en = 1'b0;
    pre_sel = ps; period = per; post_sel = post;
    tick(); tick();
    rst = 1'b0; tmr_en = 1'b1;
  endtask

  task automatic set_duty(input int c, input int val);
    duty_hi[c*8 +: 8] = 8'(val / 4);
    duty_lo[c*2 +: 2] = 2'(val % 4);
    duty_hi_we[c] = 1'b1; duty_lo_we[c] = 1'b1;
    tick();
    duty_hi_we[c] = 1'b0; duty_lo_we[c] = 1'b0;
  endtask

  task automatic wait_rise(input int c);
    bit p;
    do begin p = pwm_out[c]; tick(); end while (!(!p && pwm_out[c]));
  endtask

  task automatic period_len(output int n);
    bit p;
    wait_rise(0);
    n = 0;
    do begin p = pwm_out[0]; tick(); n++; end while (!(!p && pwm_out[0]));
  endtask

  task automatic high_len(input int c, output int n);
    wait_rise(c);
    n = 0;
    while (pwm_out[c]) begin n++; tick(); end
  endtask

  initial begin
    int n, r0, r1, h0, h1;
    bit p0, p1, frozen_ok;
    logic [1:0]  pw_hold;
    logic [19:0] dh_hold;

    // R8: reset state
    tick(); tick();
    chk(pwm_out == 2'b00 && tmr_flag == 1'b0 && duty_active == '0, "R8 reset outputs",
        {tmr_flag, pwm_out}, 0);

    // S1: PS=1, period 3 -> 16 clocks
    start(2'd0, 8'd3, 4'd0);
    set_duty(0, 6);
    set_duty(1, 11);
    period_len(n);
    chk(n == 16, "R1 period length ps1", n, 16);
    high_len(0, n);
    chk(n == 6, "R5 high time duty 6", n, 6);
    high_len(1, n);
    chk(n == 11, "R5 high time duty 11", n, 11);
    // R7: shared timer, rises coincide
    r0 = 0; r1 = 0;
    for (int i = 0; i < 48; i++) begin
      p0 = pwm_out[0]; p1 = pwm_out[1];
      tick();
      if (!p0 && pwm_out[0]) r0++;
      if (!p1 && pwm_out[1]) r1++;
      chk((!p0 && pwm_out[0]) == (!p1 && pwm_out[1]), "R7 common rise", pwm_out[1], pwm_out[0]);
    end
    chk(r0 == 3 && r1 == 3, "R7 rises per 48 clocks", r0 * 10 + r1, 33);

    // S2: split write mid-period, applied only at the boundary
    wait_rise(0);
    tick(); tick();
    duty_hi[7:0] = 8'd3; duty_hi_we[0] = 1'b1; tick(); duty_hi_we[0] = 1'b0;
    tick(); tick();
    chk(int'(duty_active[9:0]) == 6, "R4 slave held after high write", duty_active[9:0], 6);
    duty_lo[1:0] = 2'd0; duty_lo_we[0] = 1'b1; tick(); duty_lo_we[0] = 1'b0;
    chk(int'(duty_active[9:0]) == 6, "R4 slave held after low write", duty_active[9:0], 6);
    wait_rise(0);
    chk(int'(duty_active[9:0]) == 12, "R4 slave loaded at boundary", duty_active[9:0], 12);
    high_len(0, n);
    chk(n == 12, "R5 high time after reload", n, 12);

    // S3: PS=4, period 2 -> 48 clocks, duty 5 -> 20 clocks
    start(2'd1, 8'd2, 4'd0);
    set_duty(0, 5);
    period_len(n);
    chk(n == 48, "R2 period length ps4", n, 48);
    high_len(0, n);
    chk(n == 20, "R2 high time ps4", n, 20);

    // S4: select 3 gives PS=16, period 1 -> 128 clocks, duty 3 -> 48 clocks
    start(2'd3, 8'd1, 4'd0);
    set_duty(0, 3);
    period_len(n);
    chk(n == 128, "R2 period length ps16", n, 128);
    high_len(0, n);
    chk(n == 48, "R2 high time ps16", n, 48);

    // S5: R6 corners, duty 0 and duty equal to full span 12
    start(2'd0, 8'd2, 4'd0);
    set_duty(0, 0);
    set_duty(1, 12);
    while (int'(duty_active[19:10]) != 12) tick();
    h0 = 0; h1 = 0;
    for (int i = 0; i < 50; i++) begin
      tick();
      if (pwm_out[0]) h0++;
      if (pwm_out[1]) h1++;
    end
    chk(h0 == 0, "R6 zero duty stays low", h0, 0);
    chk(h1 == 50, "R6 full-span duty stays high", h1, 50);

    // S6: postscaler every 3rd boundary, period 8 clocks
    start(2'd0, 8'd1, 4'd2);
    set_duty(0, 3);
    while (!tmr_flag) tick();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    chk(tmr_flag == 1'b0, "R3 flag cleared", tmr_flag, 0);
    n = 1;
    while (!tmr_flag) begin tick(); n++; end
    chk(n == 24, "R3 flag interval", n, 24);

    // R1: disabled timer holds outputs while a duty write lands
    tick(); tick(); tick();
    tmr_en = 1'b0;
    tick();
    pw_hold = pwm_out; dh_hold = duty_active;
    set_duty(0, 7);
    frozen_ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (pwm_out != pw_hold || duty_active != dh_hold) frozen_ok = 1'b0;
    end
    chk(frozen_ok, "R1 hold while disabled", pwm_out, pw_hold);
    tmr_en = 1'b1;
    wait_rise(0);
    chk(int'(duty_active[9:0]) == 7, "R1 resumes and loads", duty_active[9:0], 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule